// File: doc/BRIEF.md
# Dual-Port Cipher Data Steering

This block sits between two byte-wide host ports and the data registers of a cipher core. The core itself is not part of the block. It is reached through two valid/ready handshakes: one takes bytes out of the input register, and one delivers result bytes into the output register. The block holds a 7-bit mode word. The mode word sets which host port carries plaintext and which carries ciphertext, and whether the block encrypts or decrypts. It can also shut the second port off. The block also forwards the mode word to the core.

Each port has a chip select, a one-cycle strobe, a read/write line (1 = read) and a register address. An access acts on the rising clock edge where chip select and strobe are both high. Read data is combinational while the access is asserted. The master port has three registers:

| Address | Register |
|---------|----------|
| 0 | data |
| 1 | status |
| 2 | mode |
| 3 | reserved, reads 0 |

The slave port has data at address 0 and status at address 1. The status byte carries input-full in bit 0 and output-ready in bit 1.

Two small state machines track the data registers:

- **Input register.** It has the states `IN_EMPTY` and `IN_LOADED`. The transition *host_load* goes from `IN_EMPTY` to `IN_LOADED`. The transition *core_take* goes from `IN_LOADED` back to `IN_EMPTY`.
- **Output register.** It has the states `OUT_EMPTY` and `OUT_HELD`. The transition *core_give* goes from `OUT_EMPTY` to `OUT_HELD`. The transition *host_drain* goes from `OUT_HELD` back to `OUT_EMPTY`.

Top module: `cipher_port_router`

## Requirements
- R1: After reset the mode word reads 0x04, and both status bytes read 0. In that mode word, bits [1:0] are the cipher type and reset to 00 (codebook). Bits [3:2] are the port arrangement and reset to 01. Bit 4 is encrypt and resets to 0. Bits 5 and 6 are stored and forwarded only, and reset to 0. `core_in_valid` is 0 after reset.
- R2: A master write at address 2 stores the low 7 bits of the byte into the mode word. A master read at address 2 returns the mode word with bit 7 as 0. The mode word also appears on `core_mode`.
- R3: With arrangement 01, the master port carries plaintext and the slave port carries ciphertext. With encrypt = 1, the master port owns the input register and the slave port owns the output register. With encrypt = 0, the ownership is reversed.
- R4: Arrangement 00 swaps the port roles: the slave port carries plaintext and the master port carries ciphertext. Ownership follows the encrypt bit in the same way as R3.
- R5: With arrangement 10 the master port owns both data registers. Slave strobes move no data, and slave read data is 0.
- R6: Arrangement 11 behaves exactly like arrangement 10.
- R7: In `IN_EMPTY`, a write at data address from the owning port loads the byte and enters `IN_LOADED`. `core_in_valid` is high and `core_in_data` holds the byte while in `IN_LOADED`. An edge with `core_in_ready` high returns to `IN_EMPTY`.
- R8: A data write from the non-owning port is ignored. A data write in `IN_LOADED` is ignored, and the held byte is unchanged.
- R9: `core_out_ready` is high only in `OUT_EMPTY`. A core byte offered in `OUT_HELD` is not taken, and the held byte is not overwritten.
- R10: A data read on the owning port returns the held byte and moves to `OUT_EMPTY`. A data read on the other port returns 0 and leaves the state unchanged.
- R11: Status bit 0 shows `IN_LOADED` and bit 1 shows `OUT_HELD`. Each bit shows only on the port that currently owns the matching register, and reads 0 on the other port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_cs | input | 1 | Master chip select |
| m_stb | input | 1 | Master access strobe |
| m_rw | input | 1 | Master direction, 1 = read |
| m_addr | input | 2 | Master register address |
| m_wdata | input | 8 | Master write byte |
| m_rdata | output | 8 | Master read byte |
| s_cs | input | 1 | Slave chip select |
| s_stb | input | 1 | Slave access strobe |
| s_rw | input | 1 | Slave direction, 1 = read |
| s_addr | input | 1 | Slave register address |
| s_wdata | input | 8 | Slave write byte |
| s_rdata | output | 8 | Slave read byte |
| core_mode | output | 7 | Mode word forwarded to the cipher core |
| core_in_valid | output | 1 | Input register holds a byte for the core |
| core_in_data | output | 8 | Byte offered to the core |
| core_in_ready | input | 1 | Core takes the input byte |
| core_out_valid | input | 1 | Core offers a result byte |
| core_out_data | input | 8 | Result byte from the core |
| core_out_ready | output | 1 | Output register can take a result byte |

## Verification
The bench builds the block with its default byte width of 8. At that width, every mode bit pattern fits a single master write. The bench walks all four port arrangements, each with both values of the encrypt bit. A write, a read and a status read on each port are enough to prove the ownership of both data registers in every combination. The byte width also makes the dropped mode bit 7 and the zero returns from the non-owning port directly visible.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

    typedef enum logic {
        PORT_M = 1'b0,
        PORT_S = 1'b1
    } port_e;

    typedef struct packed {
        logic       dflt_out;
        logic       mask_dir;
        logic       encrypt;
        logic [1:0] arrange;
        logic [1:0] ctype;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam mode_t MODE_RESET = '{
        dflt_out: 1'b0,
        mask_dir: 1'b0,
        encrypt:  1'b0,
        arrange:  2'b01,
        ctype:    2'b00
    };

    typedef enum logic {
        IN_EMPTY  = 1'b0,
        IN_LOADED = 1'b1
    } in_state_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_HELD  = 1'b1
    } out_state_e;

endpackage

// File: rtl/cpr_mode_reg.sv
module cpr_mode_reg
    import cpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode <= MODE_RESET;
        else if (wr_en)
            mode <= mode_t'(wdata[MODE_W-1:0]);
    end

    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode == $past(wdata[MODE_W-1:0])));

endmodule

// File: rtl/cpr_route.sv
module cpr_route
    import cpr_pkg::*;
(
    input  mode_t mode,
    output port_e in_owner,
    output port_e out_owner,
    output logic  master_only
);

    port_e plain_port;
    port_e ciph_port;

    always_comb begin
        master_only = mode.arrange[1];
        if (master_only) begin
            plain_port = PORT_M;
            ciph_port  = PORT_M;
        end else if (mode.arrange[0]) begin
            plain_port = PORT_M;
            ciph_port  = PORT_S;
        end else begin
            plain_port = PORT_S;
            ciph_port  = PORT_M;
        end
        in_owner  = mode.encrypt ? plain_port : ciph_port;
        out_owner = mode.encrypt ? ciph_port  : plain_port;
    end

endmodule

// File: rtl/cpr_in_fsm.sv
module cpr_in_fsm
    import cpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              core_ready,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    in_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IN_EMPTY;
            data    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == IN_EMPTY && load)
                data <= load_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_EMPTY:  if (load)       state_d = IN_LOADED;
            IN_LOADED: if (core_ready) state_d = IN_EMPTY;
            default:                   state_d = IN_EMPTY;
        endcase
    end

    assign full = (state_q == IN_LOADED);

    assert_take_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IN_LOADED && core_ready) |=> (state_q == IN_EMPTY));

    assert_load_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IN_EMPTY && load) |=> (full && data == $past(load_data)));

    assert_hold_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IN_LOADED && !core_ready) |=> (full && $stable(data)));

endmodule

// File: rtl/cpr_out_fsm.sv
module cpr_out_fsm
    import cpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_data,
    output logic              core_ready,
    input  logic              drain,
    output logic              held,
    output logic [DATA_W-1:0] data
);

    out_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_EMPTY;
            data    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == OUT_EMPTY && core_valid)
                data <= core_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (core_valid) state_d = OUT_HELD;
            OUT_HELD:  if (drain)      state_d = OUT_EMPTY;
            default:                   state_d = OUT_EMPTY;
        endcase
    end

    assign held       = (state_q == OUT_HELD);
    assign core_ready = (state_q == OUT_EMPTY);

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(data));

    assert_drain_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (held && drain) |=> !held);

endmodule

// File: rtl/cipher_port_router.sv
module cipher_port_router
    import cpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_cs,
    input  logic              m_stb,
    input  logic              m_rw,
    input  logic [1:0]        m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    input  logic              s_cs,
    input  logic              s_stb,
    input  logic              s_rw,
    input  logic              s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    output logic [MODE_W-1:0] core_mode,
    output logic              core_in_valid,
    output logic [DATA_W-1:0] core_in_data,
    input  logic              core_in_ready,
    input  logic              core_out_valid,
    input  logic [DATA_W-1:0] core_out_data,
    output logic              core_out_ready
);

    localparam int NPORT  = 2;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd2;

    mode_t mode;
    port_e in_owner, out_owner;
    logic  master_only;
    logic  in_full, out_held;
    logic [DATA_W-1:0] in_data, out_data;

    logic [NPORT-1:0]  p_cs, p_stb, p_rw, p_live, p_hit;
    logic [NPORT-1:0]  p_load, p_drain;
    logic [ADDR_W-1:0] p_addr  [NPORT];
    logic [DATA_W-1:0] p_wdata [NPORT];
    logic [DATA_W-1:0] p_rdata [NPORT];

    assign p_cs   = {s_cs, m_cs};
    assign p_stb  = {s_stb, m_stb};
    assign p_rw   = {s_rw, m_rw};
    assign p_live = {~master_only, 1'b1};
    assign p_addr[0]  = m_addr;
    assign p_addr[1]  = {1'b0, s_addr};
    assign p_wdata[0] = m_wdata;
    assign p_wdata[1] = s_wdata;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam port_e PID = (p == 0) ? PORT_M : PORT_S;
        logic own_in, own_out;
        logic [DATA_W-1:0] status;

        assign own_in   = (in_owner == PID);
        assign own_out  = (out_owner == PID);
        assign p_hit[p] = p_cs[p] & p_stb[p] & p_live[p];
        assign p_load[p]  = p_hit[p] & ~p_rw[p] & (p_addr[p] == A_DATA) & own_in;
        assign p_drain[p] = p_hit[p] &  p_rw[p] & (p_addr[p] == A_DATA) & own_out;
        assign status = {{(DATA_W-2){1'b0}}, out_held & own_out, in_full & own_in};

        always_comb begin
            p_rdata[p] = '0;
            if (p_hit[p] && p_rw[p]) begin
                unique case (p_addr[p])
                    A_DATA:  p_rdata[p] = own_out ? out_data : '0;
                    A_STAT:  p_rdata[p] = status;
                    A_MODE:  p_rdata[p] = (p == 0) ? {{(DATA_W-MODE_W){1'b0}}, mode} : '0;
                    default: p_rdata[p] = '0;
                endcase
            end
        end
    end

    assign m_rdata   = p_rdata[0];
    assign s_rdata   = p_rdata[1];
    assign core_mode = mode;

    logic mode_wr;
    assign mode_wr = p_hit[0] & ~p_rw[0] & (p_addr[0] == A_MODE);

    cpr_mode_reg #(.DATA_W(DATA_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mode_wr),
        .wdata (m_wdata),
        .mode  (mode)
    );

    cpr_route u_route (
        .mode        (mode),
        .in_owner    (in_owner),
        .out_owner   (out_owner),
        .master_only (master_only)
    );

    cpr_in_fsm #(.DATA_W(DATA_W)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (|p_load),
        .load_data  (p_load[1] ? p_wdata[1] : p_wdata[0]),
        .core_ready (core_in_ready),
        .full       (in_full),
        .data       (in_data)
    );

    cpr_out_fsm #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_valid (core_out_valid),
        .core_data  (core_out_data),
        .core_ready (core_out_ready),
        .drain      (|p_drain),
        .held       (out_held),
        .data       (out_data)
    );

    assign core_in_valid = in_full;
    assign core_in_data  = in_data;

    assert_one_loader_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(p_load) <= 1);

    assert_slave_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.arrange[1] && !in_full && s_cs && s_stb && !s_rw && !(m_cs && m_stb))
            |=> !in_full);

    assert_slave_no_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.arrange[1] && out_held && s_cs && s_stb && s_rw && !(m_cs && m_stb))
            |=> out_held);

    assert_slave_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode.arrange[1] |-> (s_rdata == '0));

endmodule

// File: tb/sim_cipher_port_router.sv
module sim_cipher_port_router;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_cs = 0, m_stb = 0, m_rw = 0;
    logic [1:0] m_addr = 0;
    logic [7:0] m_wdata = 0;
    logic [7:0] m_rdata;
    logic       s_cs = 0, s_stb = 0, s_rw = 0, s_addr = 0;
    logic [7:0] s_wdata = 0;
    logic [7:0] s_rdata;
    logic [6:0] core_mode;
    logic       core_in_valid, core_in_ready = 0;
    logic [7:0] core_in_data;
    logic       core_out_valid = 0, core_out_ready;
    logic [7:0] core_out_data = 0;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_port_router u0 (
        .clk(clk), .rst_n(rst_n),
        .m_cs(m_cs), .m_stb(m_stb), .m_rw(m_rw), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata),
        .s_cs(s_cs), .s_stb(s_stb), .s_rw(s_rw), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_rdata(s_rdata),
        .core_mode(core_mode),
        .core_in_valid(core_in_valid), .core_in_data(core_in_data),
        .core_in_ready(core_in_ready),
        .core_out_valid(core_out_valid), .core_out_data(core_out_data),
        .core_out_ready(core_out_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic m_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        m_cs = 1; m_stb = 1; m_rw = 0; m_addr = a; m_wdata = d;
        @(negedge clk);
        m_cs = 0; m_stb = 0;
    endtask

    task automatic m_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        m_cs = 1; m_stb = 1; m_rw = 1; m_addr = a;
        #1 d = m_rdata;
        @(negedge clk);
        m_cs = 0; m_stb = 0; m_rw = 0;
    endtask

    task automatic s_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        s_cs = 1; s_stb = 1; s_rw = 0; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_cs = 0; s_stb = 0;
    endtask

    task automatic s_rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        s_cs = 1; s_stb = 1; s_rw = 1; s_addr = a;
        #1 d = s_rdata;
        @(negedge clk);
        s_cs = 0; s_stb = 0; s_rw = 0;
    endtask

    task automatic core_take();
        @(negedge clk);
        core_in_ready = 1;
        @(negedge clk);
        core_in_ready = 0;
    endtask

    task automatic core_give(input logic [7:0] d, output logic rdy);
        @(negedge clk);
        core_out_valid = 1; core_out_data = d;
        #1 rdy = core_out_ready;
        @(negedge clk);
        core_out_valid = 0;
    endtask

    // R1: reset defaults
    task automatic t_reset();
        logic [7:0] v;
        m_rd(2'd2, v); chk("R1 mode word", v, 8'h04);
        m_rd(2'd1, v); chk("R1 master status", v, 8'h00);
        s_rd(1'b1, v); chk("R1 slave status", v, 8'h00);
        chk("R1 core_in_valid", {7'd0, core_in_valid}, 8'h00);
        chk("R1 core_out_ready", {7'd0, core_out_ready}, 8'h01);
    endtask

    // R2: mode register write and readback
    task automatic t_mode_rw();
        logic [7:0] v;
        m_wr(2'd2, 8'hFF);
        m_rd(2'd2, v); chk("R2 bit7 dropped", v, 8'h7F);
        chk("R2 core_mode", {1'b0, core_mode}, 8'h7F);
        m_wr(2'd2, 8'h2D);
        m_rd(2'd2, v); chk("R2 readback", v, 8'h2D);
        m_rd(2'd3, v); chk("R2 reserved address", v, 8'h00);
    endtask

    // One round trip: a writer port loads the input, a reader port drains the output
    task automatic round_trip(input string req, input logic [7:0] mode_v,
                              input logic wr_slave, input logic rd_slave,
                              input logic [7:0] din, input logic [7:0] dout);
        logic [7:0] v;
        logic rdy;
        m_wr(2'd2, mode_v);
        if (wr_slave) begin
            m_wr(2'd0, din ^ 8'hFF);  // non-owner write, R8
            chk({req, " R8 non-owner write ignored"}, {7'd0, core_in_valid}, 8'h00);
            s_wr(1'b0, din);
            s_rd(1'b1, v); chk({req, " R11 owner in flag"}, v, 8'h01);
            m_rd(2'd1, v); chk({req, " R11 other in flag"}, v, 8'h00);
        end else begin
            s_wr(1'b0, din ^ 8'hFF);
            chk({req, " R8 non-owner write ignored"}, {7'd0, core_in_valid}, 8'h00);
            m_wr(2'd0, din);
            m_rd(2'd1, v); chk({req, " R11 owner in flag"}, v, 8'h01);
            s_rd(1'b1, v); chk({req, " R11 other in flag"}, v, 8'h00);
        end
        chk({req, " R7 core_in_data"}, core_in_data, din);
        core_take();
        chk({req, " R7 taken"}, {7'd0, core_in_valid}, 8'h00);
        core_give(dout, rdy);
        chk({req, " R9 ready when empty"}, {7'd0, rdy}, 8'h01);
        if (rd_slave) begin
            m_rd(2'd0, v); chk({req, " R10 non-owner read"}, v, 8'h00);
            s_rd(1'b1, v); chk({req, " R11 owner out flag"}, v, 8'h02);
            s_rd(1'b0, v); chk({req, " R10 owner read"}, v, dout);
            s_rd(1'b1, v); chk({req, " R10 flag cleared"}, v, 8'h00);
        end else begin
            s_rd(1'b0, v); chk({req, " R10 non-owner read"}, v, 8'h00);
            m_rd(2'd1, v); chk({req, " R11 owner out flag"}, v, 8'h02);
            m_rd(2'd0, v); chk({req, " R10 owner read"}, v, dout);
            m_rd(2'd1, v); chk({req, " R10 flag cleared"}, v, 8'h00);
        end
    endtask

    // R3: arrangement 01, both directions
    task automatic t_arr01();
        round_trip("R3 enc", 8'h14, 1'b0, 1'b1, 8'hA5, 8'h5A);
        round_trip("R3 dec", 8'h04, 1'b1, 1'b0, 8'h3C, 8'hC3);
    endtask

    // R4: arrangement 00, both directions
    task automatic t_arr00();
        round_trip("R4 enc", 8'h10, 1'b1, 1'b0, 8'h66, 8'h99);
        round_trip("R4 dec", 8'h00, 1'b0, 1'b1, 8'h81, 8'h18);
    endtask

    // R8: write while loaded is ignored
    task automatic t_full_write();
        logic [7:0] v;
        m_wr(2'd2, 8'h14);
        m_wr(2'd0, 8'h11);
        m_wr(2'd0, 8'h22);
        chk("R8 held byte kept", core_in_data, 8'h11);
        core_take();
        m_rd(2'd1, v); chk("R8 flag after take", v, 8'h00);
    endtask

    // R9: core byte refused while output held
    task automatic t_backpressure();
        logic [7:0] v;
        logic rdy;
        m_wr(2'd2, 8'h14);
        core_give(8'h11, rdy);
        core_give(8'h22, rdy);
        chk("R9 ready low when held", {7'd0, rdy}, 8'h00);
        s_rd(1'b0, v); chk("R9 first byte kept", v, 8'h11);
        core_give(8'h33, rdy);
        chk("R9 ready after drain", {7'd0, rdy}, 8'h01);
        s_rd(1'b0, v); chk("R9 next byte", v, 8'h33);
    endtask

    // R5 / R6: master-only arrangements lock out the slave port
    task automatic master_only(input string req, input logic [7:0] mode_v);
        logic [7:0] v;
        logic rdy;
        m_wr(2'd2, mode_v);
        s_wr(1'b0, 8'h77);
        chk({req, " slave write ignored"}, {7'd0, core_in_valid}, 8'h00);
        m_wr(2'd0, 8'h4E);
        chk({req, " master loads"}, core_in_data, 8'h4E);
        core_give(8'hE4, rdy);
        m_rd(2'd1, v); chk({req, " master sees both flags"}, v, 8'h03);
        s_rd(1'b1, v); chk({req, " slave status blank"}, v, 8'h00);
        s_rd(1'b0, v); chk({req, " slave read blank"}, v, 8'h00);
        m_rd(2'd1, v); chk({req, " slave read no drain"}, v, 8'h03);
        m_rd(2'd0, v); chk({req, " master drains"}, v, 8'hE4);
        core_take();
        m_rd(2'd1, v); chk({req, " flags clear"}, v, 8'h00);
    endtask

    task automatic t_master_only();
        master_only("R5 enc", 8'h18);
        master_only("R5 dec", 8'h08);
        master_only("R6 enc", 8'h1C);
        master_only("R6 dec", 8'h0C);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_rw();
        t_arr01();
        t_arr00();
        t_full_write();
        t_backpressure();
        t_master_only();
        repeat (2) @(negedge clk);
        report();
    end

endmodule